// File: doc/BRIEF.md
# PCM Codec Serial Control Port

This block is the digital front end of a telephone-line PCM codec. Each 125 µs frame, an active-low sync input opens a window of eight bit clocks. In that window the block shifts one 8-bit PCM word out, shifts one PCM word in, and captures one serial control word. All words travel most significant bit first, so the first bit lines up with the PCM sign bit.

The control word goes to one of two control registers. In single-window operation it always lands in the function register. In dual-window operation the sync input falls twice per frame. A select input, low in the first window and high in the second, steers the word to the function register and then to the test register.

The function register holds the operating mode, the transmit gain code and the receive gain code. The modes are normal, analog loopback, digital loopback and powerdown. The test register selects a test path. Digital loopback and powerdown change the PCM path inside this block. The encoder, the decoder and the analog switching sit outside it and connect through plain digital ports. After reset, both registers hold their powerdown contents for a fixed start-up period and reject writes during that time.

Top module: `pcm_ctrl_port`

## Requirements
- R1: While reset is asserted and for the first 25 rising clock edges after it is released, the function register holds 8'hC0 and the test register holds 8'h00. This shows as pwr_down=1, both gain outputs 0 and test_mode=0. A control word completed on any of those edges is discarded.
- R2: The control word is shifted in MSB first, so the first window bit is bit 7. Function register bits 2:0 appear on tx_gain and bits 5:3 appear on rx_gain.
- R3: With dual_win=0, a completed control word always loads the function register, whatever the value of reg_sel.
- R4: With dual_win=1, a word completed with reg_sel=0 loads the function register and one completed with reg_sel=1 loads the test register. The other register is left unchanged.
- R5: Function register bits 7:6 select the mode. 00 is normal with no flag set, 01 sets ana_loop, 10 sets dig_loop and 11 sets pwr_down. At most one of these flags is high at a time.
- R6: When not in powerdown, pcm_out presents the enc_data word MSB first during the eight window cycles, and pcm_oe is high for exactly those cycles. The cycle after the eighth bit, dec_valid pulses high for one cycle and dec_data holds the received word.
- R7: In digital loopback, the next window transmits the last received PCM word instead of enc_data, and dec_data reads 0.
- R8: In powerdown, pcm_oe stays low throughout the window. Control words are still accepted and can leave powerdown.
- R9: A window that ends before eight bits leaves both registers unchanged and raises no dec_valid.
- R10: test_mode shows test register bits 7:6. The value 00 means no test path is active.
- R11: pcm_oe is low whenever sync_n is high. It is also low on any cycle after the eighth while sync_n stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_n | input | 1 | Frame sync window, active low |
| dual_win | input | 1 | 1 selects two windows per frame |
| reg_sel | input | 1 | Target register in dual-window mode (0 function, 1 test) |
| ctl_in | input | 1 | Serial control data |
| pcm_in | input | 1 | Serial PCM receive data |
| enc_data | input | 8 | Word from the encoder, to be transmitted |
| pcm_out | output | 1 | Serial PCM transmit data, 0 when not enabled |
| pcm_oe | output | 1 | Output enable for the PCM transmit pad |
| dec_data | output | 8 | Received word for the decoder |
| dec_valid | output | 1 | One-cycle pulse when dec_data is updated |
| tx_gain | output | 3 | Transmit gain code |
| rx_gain | output | 3 | Receive gain code |
| ana_loop | output | 1 | Analog loopback selected |
| dig_loop | output | 1 | Digital loopback selected |
| pwr_down | output | 1 | Powerdown selected |
| test_mode | output | 2 | Selected test path |

## Verification
The assertions assume that sync_n, pcm_in and ctl_in are stable around each rising edge. They also assume that dual_win and reg_sel do not change inside a window, and that consecutive windows are separated by at least one cycle with sync_n high, since the transmit word loads only in that gap. The bench changes every input on the falling clock edge and holds reg_sel for a whole window. It keeps at least one high-sync cycle between windows, so the stimulus stays within these assumptions. Windows cut short or held too long are applied on purpose, and the checks cover both cases.

// File: rtl/pcm_ctrl_pkg.sv
package pcm_ctrl_pkg;
  localparam int WORD_W   = 8;
  localparam int INIT_CYC = 25;

  typedef enum logic [1:0] {
    FN_NORMAL = 2'b00,
    FN_ALOOP  = 2'b01,
    FN_DLOOP  = 2'b10,
    FN_PDOWN  = 2'b11
  } fn_e;

  localparam logic [WORD_W-1:0] FUNC_RST = 8'hC0;
  localparam logic [WORD_W-1:0] TEST_RST = 8'h00;

  function automatic fn_e fn_of(input logic [WORD_W-1:0] r);
    return fn_e'(r[7:6]);
  endfunction

  function automatic logic [2:0] txg_of(input logic [WORD_W-1:0] r);
    return r[2:0];
  endfunction

  function automatic logic [2:0] rxg_of(input logic [WORD_W-1:0] r);
    return r[5:3];
  endfunction
endpackage

// File: rtl/pcm_win_timer.sv
module pcm_win_timer #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  output logic win_act,
  output logic word_done
);
  localparam int CW = $clog2(W + 1);
  logic [CW-1:0] cnt;

  assign win_act   = !sync_n && (cnt != CW'(W));
  assign word_done = win_act && (cnt == CW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (sync_n)  cnt <= '0;
    else if (win_act) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pcm_ctl_bank.sv
module pcm_ctl_bank
  import pcm_ctrl_pkg::*;
#(
  parameter int W        = WORD_W,
  parameter int INIT_LEN = INIT_CYC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_in,
  input  logic         win_act,
  input  logic         word_done,
  input  logic         dual_win,
  input  logic         reg_sel,
  output logic [W-1:0] func_reg,
  output logic [W-1:0] test_reg,
  output logic         init_busy
);
  localparam int IW = $clog2(INIT_LEN + 1);
  logic [IW-1:0] init_cnt;
  logic [W-1:0]  sr;
  logic [W-1:0]  word;
  logic          to_test;

  assign init_busy = (init_cnt != IW'(INIT_LEN));
  assign word      = {sr[W-2:0], ctl_in};
  assign to_test   = dual_win && reg_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         init_cnt <= '0;
    else if (init_busy) init_cnt <= init_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr <= '0;
    else if (win_act) sr <= word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_reg <= FUNC_RST;
      test_reg <= TEST_RST;
    end else if (init_busy) begin
      func_reg <= FUNC_RST;
      test_reg <= TEST_RST;
    end else if (word_done) begin
      if (to_test) test_reg <= word;
      else         func_reg <= word;
    end
  end
endmodule

// File: rtl/pcm_data_lane.sv
module pcm_data_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sync_n,
  input  logic         pcm_in,
  input  logic         win_act,
  input  logic         word_done,
  input  logic         loop_dig,
  input  logic [W-1:0] enc_data,
  output logic         tx_bit,
  output logic [W-1:0] dec_data,
  output logic         dec_valid
);
  logic [W-1:0] rx_sr;
  logic [W-1:0] rx_word;
  logic [W-1:0] tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr     <= '0;
      rx_word   <= '0;
      dec_valid <= 1'b0;
    end else begin
      dec_valid <= word_done;
      if (win_act)   rx_sr   <= {rx_sr[W-2:0], pcm_in};
      if (word_done) rx_word <= {rx_sr[W-2:0], pcm_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tx_sr <= '0;
    else if (sync_n)  tx_sr <= loop_dig ? rx_word : enc_data;
    else if (win_act) tx_sr <= {tx_sr[W-2:0], 1'b0};
  end

  assign tx_bit   = tx_sr[W-1];
  assign dec_data = loop_dig ? '0 : rx_word;
endmodule

// File: rtl/pcm_ctrl_port.sv
module pcm_ctrl_port
  import pcm_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_n,
  input  logic       dual_win,
  input  logic       reg_sel,
  input  logic       ctl_in,
  input  logic       pcm_in,
  input  logic [7:0] enc_data,
  output logic       pcm_out,
  output logic       pcm_oe,
  output logic [7:0] dec_data,
  output logic       dec_valid,
  output logic [2:0] tx_gain,
  output logic [2:0] rx_gain,
  output logic       ana_loop,
  output logic       dig_loop,
  output logic       pwr_down,
  output logic [1:0] test_mode
);
  localparam int W = WORD_W;

  logic         win_act;
  logic         word_done;
  logic         init_busy;
  logic         tx_bit;
  logic [W-1:0] func_reg;
  logic [W-1:0] test_reg;
  fn_e          fn;

  pcm_win_timer #(.W(W)) u_timer (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n),
    .win_act(win_act), .word_done(word_done)
  );

  pcm_ctl_bank #(.W(W), .INIT_LEN(INIT_CYC)) u_bank (
    .clk(clk), .rst_n(rst_n), .ctl_in(ctl_in),
    .win_act(win_act), .word_done(word_done),
    .dual_win(dual_win), .reg_sel(reg_sel),
    .func_reg(func_reg), .test_reg(test_reg), .init_busy(init_busy)
  );

  pcm_data_lane #(.W(W)) u_lane (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .pcm_in(pcm_in),
    .win_act(win_act), .word_done(word_done), .loop_dig(dig_loop),
    .enc_data(enc_data), .tx_bit(tx_bit),
    .dec_data(dec_data), .dec_valid(dec_valid)
  );

  assign fn        = fn_of(func_reg);
  assign ana_loop  = (fn == FN_ALOOP);
  assign dig_loop  = (fn == FN_DLOOP);
  assign pwr_down  = (fn == FN_PDOWN);
  assign tx_gain   = txg_of(func_reg);
  assign rx_gain   = rxg_of(func_reg);
  assign test_mode = test_reg[7:6];

  assign pcm_oe  = win_act && !pwr_down;
  assign pcm_out = pcm_oe && tx_bit;
endmodule

// File: rtl/pcm_ctrl_chk.sv
module pcm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_n,
  input logic       pcm_oe,
  input logic       pwr_down,
  input logic       ana_loop,
  input logic       dig_loop,
  input logic       dec_valid,
  input logic       init_busy,
  input logic       word_done,
  input logic [2:0] tx_gain,
  input logic [2:0] rx_gain,
  input logic [1:0] test_mode
);
  AST_OE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_oe |-> !sync_n); // R11
  AST_PD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> !pcm_oe); // R8
  AST_INIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> (pwr_down && test_mode == 2'b00 && tx_gain == 3'd0)); // R1
  AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ana_loop, dig_loop, pwr_down})); // R5
  AST_VALID_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(word_done)); // R6
  AST_FUNC_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({tx_gain, rx_gain, ana_loop, dig_loop, pwr_down}) |-> $past(word_done)); // R9
  AST_TEST_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(test_mode) |-> $past(word_done)); // R10
endmodule

bind pcm_ctrl_port pcm_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .pcm_oe(pcm_oe),
  .pwr_down(pwr_down), .ana_loop(ana_loop), .dig_loop(dig_loop),
  .dec_valid(dec_valid), .init_busy(init_busy), .word_done(word_done),
  .tx_gain(tx_gain), .rx_gain(rx_gain), .test_mode(test_mode)
);

// File: tb/pcm_ctrl_port_test.sv
module pcm_ctrl_port_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_n = 1'b1;
  logic       dual_win = 1'b0;
  logic       reg_sel = 1'b0;
  logic       ctl_in = 1'b0;
  logic       pcm_in = 1'b0;
  logic [7:0] enc_data = 8'h00;
  logic       pcm_out, pcm_oe, dec_valid, ana_loop, dig_loop, pwr_down;
  logic [7:0] dec_data;
  logic [2:0] tx_gain, rx_gain;
  logic [1:0] test_mode;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_ctrl_port uut (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .dual_win(dual_win),
    .reg_sel(reg_sel), .ctl_in(ctl_in), .pcm_in(pcm_in), .enc_data(enc_data),
    .pcm_out(pcm_out), .pcm_oe(pcm_oe), .dec_data(dec_data), .dec_valid(dec_valid),
    .tx_gain(tx_gain), .rx_gain(rx_gain), .ana_loop(ana_loop), .dig_loop(dig_loop),
    .pwr_down(pwr_down), .test_mode(test_mode)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // One window of nbits cycles; inputs change on falling edges.
  task automatic frame(input logic [7:0] pcm_w, input logic [7:0] ctl_w,
                       input logic sel, input int nbits,
                       output logic [7:0] got, output int oe_cnt);
    got = 8'h00;
    oe_cnt = 0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      sync_n  = 1'b0;
      reg_sel = sel;
      pcm_in  = (i < 8) ? pcm_w[7-i] : 1'b0;
      ctl_in  = (i < 8) ? ctl_w[7-i] : 1'b0;
      #1;
      if (pcm_oe) begin
        oe_cnt++;
        if (i < 8) got[7-i] = pcm_out;
      end
    end
    @(negedge clk);
    sync_n = 1'b1;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [7:0] g; int oc;
    chk_eq("R1 pwr_down after reset", pwr_down, 1);
    chk_eq("R1 tx_gain after reset", tx_gain, 0);
    chk_eq("R1 test_mode after reset", test_mode, 0);
    chk_eq("R11 oe idle", pcm_oe, 0);
    frame(8'h00, 8'h1D, 1'b0, 8, g, oc);
    chk_eq("R1 early write ignored pd", pwr_down, 1);
    chk_eq("R1 early write ignored gain", tx_gain, 0);
    chk_eq("R8 no oe in powerdown", oc, 0);
    idle(30);
  endtask

  task automatic t_normal;
    logic [7:0] g; int oc;
    dual_win = 1'b0;
    frame(8'h00, 8'h1D, 1'b1, 8, g, oc);
    chk_eq("R3 single-window writes function reg", pwr_down, 0);
    chk_eq("R2 tx_gain", tx_gain, 5);
    chk_eq("R2 rx_gain", rx_gain, 3);
    chk_eq("R3 test reg untouched", test_mode, 0);
    idle(2);
    enc_data = 8'hA5;
    frame(8'h3C, 8'h1D, 1'b0, 8, g, oc);
    chk_eq("R6 tx word", g, 8'hA5);
    chk_eq("R6 oe count", oc, 8);
    chk_eq("R6 dec_valid", dec_valid, 1);
    chk_eq("R6 dec_data", dec_data, 8'h3C);
    chk_eq("R11 oe after window", pcm_oe, 0);
    idle(1);
    chk_eq("R6 dec_valid one cycle", dec_valid, 0);
    enc_data = 8'h5A;
    frame(8'hC3, 8'h1D, 1'b0, 8, g, oc);
    chk_eq("R6 tx word 2", g, 8'h5A);
    chk_eq("R6 dec_data 2", dec_data, 8'hC3);
    idle(2);
  endtask

  task automatic t_aloop;
    logic [7:0] g; int oc;
    frame(8'h00, 8'h40, 1'b0, 8, g, oc);
    chk_eq("R5 ana_loop", {ana_loop, dig_loop, pwr_down}, 3'b100);
    idle(2);
  endtask

  task automatic t_dloop;
    logic [7:0] g; int oc;
    enc_data = 8'hFF;
    frame(8'h00, 8'h96, 1'b0, 8, g, oc);
    chk_eq("R5 dig_loop", {ana_loop, dig_loop, pwr_down}, 3'b010);
    chk_eq("R2 gains 10_010_110", {rx_gain, tx_gain}, 6'b010110);
    idle(2);
    frame(8'h96, 8'h96, 1'b0, 8, g, oc);
    chk_eq("R7 dec_data zero", dec_data, 0);
    chk_eq("R7 dec_valid still pulses", dec_valid, 1);
    idle(2);
    frame(8'h00, 8'h96, 1'b0, 8, g, oc);
    chk_eq("R7 looped word", g, 8'h96);
    idle(2);
  endtask

  task automatic t_dual;
    logic [7:0] g; int oc;
    dual_win = 1'b1;
    frame(8'h00, 8'h0A, 1'b0, 8, g, oc);
    idle(1);
    frame(8'h00, 8'h80, 1'b1, 8, g, oc);
    chk_eq("R4 function reg from first window", {rx_gain, tx_gain}, 6'b001010);
    chk_eq("R4 mode normal", {ana_loop, dig_loop, pwr_down}, 3'b000);
    chk_eq("R10 test_mode", test_mode, 2);
    idle(2);
    frame(8'h00, 8'hC0, 1'b1, 8, g, oc);
    chk_eq("R10 test_mode 3", test_mode, 3);
    chk_eq("R4 function reg untouched", pwr_down, 0);
    dual_win = 1'b0;
    idle(2);
  endtask

  task automatic t_short;
    logic [7:0] g; int oc;
    frame(8'hFF, 8'hFF, 1'b0, 5, g, oc);
    chk_eq("R9 no dec_valid", dec_valid, 0);
    chk_eq("R9 regs unchanged", {pwr_down, rx_gain, tx_gain}, 7'b0001010);
    idle(2);
  endtask

  task automatic t_pd_long;
    logic [7:0] g; int oc;
    frame(8'h00, 8'hC7, 1'b0, 8, g, oc);
    chk_eq("R8 pwr_down set", pwr_down, 1);
    idle(2);
    frame(8'h00, 8'h01, 1'b0, 8, g, oc);
    chk_eq("R8 oe low in powerdown", oc, 0);
    chk_eq("R8 write accepted in powerdown", {pwr_down, tx_gain}, 4'b0001);
    idle(2);
    enc_data = 8'h81;
    frame(8'h24, 8'h02, 1'b0, 10, g, oc);
    chk_eq("R11 oe only 8 cycles", oc, 8);
    chk_eq("R11 word in long window", g, 8'h81);
    chk_eq("R2 long window ctl", tx_gain, 2);
    idle(2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_normal();
    t_aloop();
    t_dloop();
    t_dual();
    t_short();
    t_pd_long();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule